// File: doc/BRIEF.md
# Flash Page Load and Program Controller

This block is the write half of a byte-wide, page-organised flash model, built as a synchronous controller. The host presents bytes through active-low chip-select, write-strobe and output-enable lines, with a byte address and a data byte. Each qualified byte goes into a page buffer. The first byte of a load fixes the page. Every byte accepted after it restarts an inactivity window. When that window runs out with no new byte, the controller starts an internal program cycle of fixed length. While `busy` is high, the cycle copies the whole buffer into a behavioural array, and any position not loaded is written as erased (all ones).

After reset, the controller refuses writes for a fixed number of cycles, which models the delay after power-up. A write strobe that is too short is ignored. So is a strobe made while output enable is low or chip select is high. A byte that names a different page from the one already latched is dropped and raises a sticky error flag. A read port returns stored bytes so the result of each program cycle can be observed.

The array keeps `STORE_PAGES` rows, and a page is placed in the row given by the low bits of its page number. All times are given in clock cycles, so a simulation can use short values.

Top module: `pgflash_page_writer`

## Requirements
- R1: After reset, `busy` and `page_err` are 0, and every array byte reads as FF hex.
- R2: For `PWRUP_CYC` cycles after reset is released, qualified byte loads are ignored. They start no load, and they change no array content.
- R3: A byte is accepted only when `ce_n`=0, `we_n`=0 and `oe_n`=1 have held for `MIN_PULSE` consecutive clock edges. One such pulse gives exactly one byte, on its `MIN_PULSE`-th edge. A shorter pulse is ignored. So is any pulse with `oe_n`=0 or `ce_n`=1.
- R4: Address bits [18:8] give the page number and bits [7:0] give the byte offset. The first accepted byte latches the page, and later bytes of the same page may arrive at any offset, in any order.
- R5: A byte whose page differs from the latched page is dropped and sets `page_err`. `page_err` stays 1 until the edge on which the program cycle begins, and there it returns to 0.
- R6: A byte extends the load if its accepting edge comes at most `LOAD_WIN` edges after the previous accepted byte. `busy` rises exactly `LOAD_WIN` edges after the last accepted byte.
- R7: `busy` stays high for exactly `PROG_CYC` cycles. Byte loads made while it is high are ignored.
- R8: When `busy` falls, the page row holds every loaded byte. Every offset not loaded in that load holds FF hex, even if an earlier program wrote it. Other rows keep their contents.
- R9: `rd_data` shows the byte at `rd_addr` one clock edge after the address is presented. The row is selected by page number modulo `STORE_PAGES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; release marks power reaching its sense level |
| ce_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable; low inhibits writes |
| addr | input | 19 | Byte-load address: page [18:8], offset [7:0] |
| wdata | input | 8 | Byte-load data |
| rd_addr | input | 19 | Read address |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | High during the internal program cycle |
| page_err | output | 1 | Sticky flag for a dropped byte from a different page |

## Verification
Most internal faults in this block first show up in the array contents, so they appear at the ports only after `busy` falls and the row is read back. A wrong page latch puts bytes in the wrong row. A stale valid bit puts old data where FF was expected. A bad offset decode misplaces a byte inside the row. An off-by-one in the shared cycle counter is visible sooner: `busy` rises one edge early or late after the last byte, or it stays high for the wrong number of cycles. A faulty strobe qualifier shows as a missing byte, or as a program cycle that starts when no valid byte was loaded.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

   typedef enum logic [1:0] {
      PGW_LOCK = 2'd0,
      PGW_IDLE = 2'd1,
      PGW_LOAD = 2'd2,
      PGW_PROG = 2'd3
   } pgw_state_e;

   function automatic int unsigned pgw_max3(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/pgw_strobe_qual.sv
module pgw_strobe_qual #(
   parameter int unsigned MIN_PULSE = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic we_n,
   input  logic oe_n,
   output logic accept
);

   logic wr_cond;
   assign wr_cond = !ce_n && !we_n && oe_n;

   generate
      if (MIN_PULSE < 1) begin : g_bad_pulse
         $error("pgw_strobe_qual: MIN_PULSE must be at least 1");
      end

      if (MIN_PULSE == 1) begin : g_edge
         logic cond_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cond_q <= 1'b0;
            else        cond_q <= wr_cond;
         end
         assign accept = wr_cond && !cond_q;
      end else begin : g_count
         localparam int unsigned HW = $clog2(MIN_PULSE + 1);
         localparam logic [HW-1:0] HOLD_SAT  = HW'(MIN_PULSE);
         localparam logic [HW-1:0] HOLD_FIRE = HW'(MIN_PULSE - 1);
         logic [HW-1:0] held_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                held_q <= '0;
            else if (!wr_cond)         held_q <= '0;
            else if (held_q != HOLD_SAT) held_q <= held_q + 1'b1;
         end
         assign accept = wr_cond && (held_q == HOLD_FIRE);
      end
   endgenerate

   // R3
   single_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !accept)
      else $error("one write pulse produced more than one byte");

endmodule

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
   parameter int unsigned OFF_W  = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   wr_en,
   input  logic [OFF_W-1:0]                       wr_off,
   input  logic [DATA_W-1:0]                      wr_data,
   input  logic                                   clr,
   output logic [(1<<OFF_W)-1:0][DATA_W-1:0]      image,
   output logic [(1<<OFF_W)-1:0]                  valid_vec
);

   localparam int unsigned PAGE_BYTES = 1 << OFF_W;

   generate
      if (OFF_W < 1 || OFF_W > 10) begin : g_bad_off
         $error("pgw_page_buf: OFF_W out of supported range");
      end

      for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_cell
         logic [DATA_W-1:0] d_q;
         logic              v_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               d_q <= '0;
               v_q <= 1'b0;
            end else if (clr) begin
               v_q <= 1'b0;
            end else if (wr_en && (wr_off == OFF_W'(b))) begin
               d_q <= wr_data;
               v_q <= 1'b1;
            end
         end
         assign image[b]     = v_q ? d_q : {DATA_W{1'b1}};
         assign valid_vec[b] = v_q;
      end
   endgenerate

endmodule

// File: rtl/pgw_page_store.sv
module pgw_page_store #(
   parameter int unsigned ROWS   = 4,
   parameter int unsigned OFF_W  = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   commit,
   input  logic [$clog2(ROWS)-1:0]                commit_row,
   input  logic [(1<<OFF_W)-1:0][DATA_W-1:0]      image,
   input  logic [$clog2(ROWS)-1:0]                rd_row,
   input  logic [OFF_W-1:0]                       rd_off,
   output logic [DATA_W-1:0]                      rd_data
);

   localparam int unsigned ROW_W      = $clog2(ROWS);
   localparam int unsigned PAGE_BYTES = 1 << OFF_W;

   logic [PAGE_BYTES-1:0][DATA_W-1:0] row_view [ROWS];

   generate
      if (ROWS < 2 || (1 << ROW_W) != ROWS) begin : g_bad_rows
         $error("pgw_page_store: ROWS must be a power of two, at least 2");
      end

      for (genvar r = 0; r < ROWS; r++) begin : g_row
         logic [PAGE_BYTES-1:0][DATA_W-1:0] row_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               row_q <= '1;
            else if (commit && (commit_row == ROW_W'(r)))
               row_q <= image;
         end
         assign row_view[r] = row_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_data <= '0;
      else        rd_data <= row_view[rd_row][rd_off];
   end

endmodule

// File: rtl/pgflash_page_writer.sv
module pgflash_page_writer
   import pgw_pkg::*;
#(
   parameter int unsigned ADDR_W      = 19,
   parameter int unsigned OFF_W       = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned STORE_PAGES = 4,
   parameter int unsigned MIN_PULSE   = 1,
   parameter int unsigned LOAD_WIN    = 7500,
   parameter int unsigned PROG_CYC    = 250000,
   parameter int unsigned PWRUP_CYC   = 500000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              page_err
);

   localparam int unsigned PG_W       = ADDR_W - OFF_W;
   localparam int unsigned PAGE_BYTES = 1 << OFF_W;
   localparam int unsigned ROW_W      = $clog2(STORE_PAGES);
   localparam int unsigned CNT_MAX    = pgw_max3(LOAD_WIN, PROG_CYC, PWRUP_CYC);
   localparam int unsigned CNT_W      = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] WIN_LOAD  = CNT_W'(LOAD_WIN - 1);
   localparam logic [CNT_W-1:0] PROG_LOAD = CNT_W'(PROG_CYC - 1);
   localparam logic [CNT_W-1:0] LOCK_LOAD = CNT_W'(PWRUP_CYC - 1);

   generate
      if (ADDR_W <= OFF_W + ROW_W) begin : g_bad_addr
         $error("pgflash_page_writer: ADDR_W too small for OFF_W and STORE_PAGES");
      end
      if (LOAD_WIN < 1 || PROG_CYC < 1 || PWRUP_CYC < 1) begin : g_bad_time
         $error("pgflash_page_writer: cycle counts must be at least 1");
      end
   endgenerate

   pgw_state_e        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [PG_W-1:0]   page_q;
   logic              err_q;

   logic              acc;
   logic [PG_W-1:0]   acc_page;
   logic [OFF_W-1:0]  acc_off;
   logic              page_hit;
   logic              buf_wr;
   logic              commit;
   logic              cnt_zero;

   logic [PAGE_BYTES-1:0][DATA_W-1:0] image;
   logic [PAGE_BYTES-1:0]             valid_vec;
   logic                              unused_rd_hi;

   assign acc_page = addr[ADDR_W-1:OFF_W];
   assign acc_off  = addr[OFF_W-1:0];
   assign page_hit = (acc_page == page_q);
   assign cnt_zero = (cnt_q == '0);
   assign buf_wr   = acc && ((state_q == PGW_IDLE) ||
                             ((state_q == PGW_LOAD) && page_hit));
   assign commit   = (state_q == PGW_PROG) && cnt_zero;

   pgw_strobe_qual #(
      .MIN_PULSE (MIN_PULSE)
   ) u_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .ce_n   (ce_n),
      .we_n   (we_n),
      .oe_n   (oe_n),
      .accept (acc)
   );

   pgw_page_buf #(
      .OFF_W  (OFF_W),
      .DATA_W (DATA_W)
   ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (buf_wr),
      .wr_off    (acc_off),
      .wr_data   (wdata),
      .clr       (commit),
      .image     (image),
      .valid_vec (valid_vec)
   );

   pgw_page_store #(
      .ROWS   (STORE_PAGES),
      .OFF_W  (OFF_W),
      .DATA_W (DATA_W)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit     (commit),
      .commit_row (page_q[ROW_W-1:0]),
      .image      (image),
      .rd_row     (rd_addr[OFF_W +: ROW_W]),
      .rd_off     (rd_addr[OFF_W-1:0]),
      .rd_data    (rd_data)
   );

   assign unused_rd_hi = ^rd_addr[ADDR_W-1:OFF_W+ROW_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PGW_LOCK;
         cnt_q   <= LOCK_LOAD;
         page_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         case (state_q)
            PGW_LOCK: begin
               if (cnt_zero) state_q <= PGW_IDLE;
               else          cnt_q   <= cnt_q - 1'b1;
            end
            PGW_IDLE: begin
               if (acc) begin
                  page_q  <= acc_page;
                  cnt_q   <= WIN_LOAD;
                  state_q <= PGW_LOAD;
               end
            end
            PGW_LOAD: begin
               if (acc && page_hit) begin
                  cnt_q <= WIN_LOAD;
               end else begin
                  if (acc) err_q <= 1'b1;
                  if (cnt_zero) begin
                     state_q <= PGW_PROG;
                     cnt_q   <= PROG_LOAD;
                     err_q   <= 1'b0;
                  end else begin
                     cnt_q <= cnt_q - 1'b1;
                  end
               end
            end
            default: begin
               if (cnt_zero) state_q <= PGW_IDLE;
               else          cnt_q   <= cnt_q - 1'b1;
            end
         endcase
      end
   end

   assign busy     = (state_q == PGW_PROG);
   assign page_err = err_q;

   // R2
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PGW_LOCK) |=> (state_q == PGW_LOCK || state_q == PGW_IDLE))
      else $error("write accepted during power-on lockout");

   // R4
   page_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PGW_LOAD && $past(state_q) == PGW_LOAD) |-> $stable(page_q))
      else $error("latched page changed during a load");

   // R5
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !page_err)
      else $error("page error still set when programming began");

   // R7
   busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(valid_vec))
      else $error("page buffer written while busy");

endmodule

// File: tb/tb_pgflash_page_writer.sv
module tb_pgflash_page_writer;

   localparam int CLK_PERIOD = 10;
   localparam int L  = 6;
   localparam int PC = 10;
   localparam int PU = 20;
   localparam int P  = 2;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        ce_n, we_n, oe_n;
   logic [18:0] addr;
   logic [7:0]  wdata;
   logic [18:0] rd_addr;
   logic [7:0]  rd_data;
   logic        busy;
   logic        page_err;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pgflash_page_writer #(
      .ADDR_W      (19),
      .OFF_W       (8),
      .DATA_W      (8),
      .STORE_PAGES (4),
      .MIN_PULSE   (P),
      .LOAD_WIN    (L),
      .PROG_CYC    (PC),
      .PWRUP_CYC   (PU)
   ) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .ce_n     (ce_n),
      .we_n     (we_n),
      .oe_n     (oe_n),
      .addr     (addr),
      .wdata    (wdata),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .busy     (busy),
      .page_err (page_err)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // pulse of given length with given control levels; starts and ends at a negedge
   task automatic pulse(input logic c, input logic w, input logic o,
                        input logic [18:0] a, input logic [7:0] d, input int len);
      ce_n = c; we_n = w; oe_n = o; addr = a; wdata = d;
      repeat (len) @(posedge clk);
      @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      tick();
   endtask

   task automatic load_byte(input logic [18:0] a, input logic [7:0] d);
      pulse(1'b0, 1'b0, 1'b1, a, d, P);
   endtask

   task automatic read_chk(input string req, input logic [18:0] a, input logic [7:0] exp);
      rd_addr = a;
      tick();
      check(req, int'(rd_data), int'(exp));
   endtask

   task automatic wait_prog_done();
      int t;
      t = 0;
      while (!busy && t < 100) begin tick(); t++; end
      t = 0;
      while (busy && t < 100) begin tick(); t++; end
   endtask

   function automatic logic [7:0] exp_byte(input int p, input int k);
      case (p)
         0: return (k == 0) ? 8'h5A : 8'hFF;
         1: return (k == 16) ? 8'h31 : (k == 17) ? 8'h32 : 8'hFF;
         2: return (k % 3 != 0) ? 8'((k * 7 + 3) % 256) : 8'hFF;
         default: return (k == 8) ? 8'h88 : 8'hFF;
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      addr = '0; wdata = '0; rd_addr = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 busy", busy, 0);
      check("R1 page_err", page_err, 0);

      // R2 a byte during power-on lockout is ignored
      load_byte(19'h00100, 8'h12);
      for (int i = 0; i < 40; i++) begin
         tick();
         check("R2 no program after lockout write", busy, 0);
      end
      read_chk("R2 lockout byte not stored", 19'h00100, 8'hFF);
      read_chk("R1 erased after reset", 19'h00000, 8'hFF);

      // R4 page 2, scrambled offset order, every offset not divisible by 3
      for (int i = 0; i < 256; i++) begin
         int k;
         k = (i * 37) % 256;
         if (k % 3 != 0) load_byte(19'(512 + k), 8'((k * 7 + 3) % 256));
      end
      // R6 busy rises exactly L edges after the last accepted byte (one edge already elapsed)
      for (int n = 1; n <= L; n++) begin
         if (n > 1) tick();
         check("R6 busy rise timing", busy, (n == L) ? 1 : 0);
      end
      // R7 busy lasts exactly PC cycles
      for (int m = 1; m <= PC; m++) begin
         tick();
         check("R7 busy duration", busy, (m < PC) ? 1 : 0);
      end
      // R8 loaded bytes stored, unloaded bytes FF
      for (int k = 0; k < 256; k++)
         read_chk("R8 page 2 contents", 19'(512 + k), exp_byte(2, k));
      read_chk("R8 other row untouched", 19'h00305, 8'hFF);

      // R6 byte at exactly L edges extends the load
      load_byte(19'h00305, 8'hA5);
      repeat (L - P - 1) @(posedge clk);
      @(negedge clk);
      check("R6 still loading before boundary byte", busy, 0);
      load_byte(19'h00306, 8'h66);
      // R7 byte at L+1 edges lands while busy and is ignored
      repeat (L - P) @(posedge clk);
      @(negedge clk);
      load_byte(19'h00307, 8'h77);
      check("R7 busy when late byte arrived", busy, 1);
      wait_prog_done();
      read_chk("R6 first byte", 19'h00305, 8'hA5);
      read_chk("R6 boundary byte kept", 19'h00306, 8'h66);
      read_chk("R7 byte during busy ignored", 19'h00307, 8'hFF);

      // R8 reprogramming fills previously written offsets with FF
      load_byte(19'h00308, 8'h88);
      wait_prog_done();
      read_chk("R8 old byte erased", 19'h00305, 8'hFF);
      read_chk("R8 new byte", 19'h00308, 8'h88);

      // R5 foreign-page byte dropped, sticky error, cleared at program start
      load_byte(19'h00110, 8'h31);
      check("R5 no error on same page", page_err, 0);
      load_byte(19'h00210, 8'h99);
      check("R5 error set", page_err, 1);
      load_byte(19'h00111, 8'h32);
      check("R5 error sticky", page_err, 1);
      begin
         int t;
         t = 0;
         while (!busy && t < 100) begin tick(); t++; end
      end
      check("R5 error cleared at program start", page_err, 0);
      wait_prog_done();
      read_chk("R5 dropped byte not written", 19'h00210, exp_byte(2, 16));
      read_chk("R4 latched page byte", 19'h00110, 8'h31);

      // R3 glitch and inhibit conditions
      pulse(1'b0, 1'b0, 1'b1, 19'h00000, 8'h11, 1);
      pulse(1'b0, 1'b0, 1'b0, 19'h00000, 8'h22, 4);
      pulse(1'b1, 1'b0, 1'b1, 19'h00000, 8'h33, 4);
      pulse(1'b0, 1'b1, 1'b1, 19'h00000, 8'h44, 4);
      for (int i = 0; i < L + 4; i++) begin
         tick();
         check("R3 rejected strobes start nothing", busy, 0);
      end
      read_chk("R3 rejected strobes store nothing", 19'h00000, 8'hFF);
      load_byte(19'h00000, 8'h5A);
      wait_prog_done();

      // R9 full readback of all rows, with page aliasing on row 0 (page 4)
      for (int p = 0; p < 4; p++)
         for (int k = 0; k < 256; k++)
            read_chk("R9 sweep", 19'(p * 256 + k), exp_byte(p, k));
      read_chk("R9 row alias", 19'h00400, 8'h5A);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule